// File: doc/BRIEF.md
# Dual-Mode Capture/Compare Timer Unit

This block is a four-channel timer. A prescaler divides the peripheral clock and emits a one-cycle count step. In free-running mode a single shared 32-bit counter advances on each step and serves as the time base for all four channels. Events never clear this counter. In split mode each channel has its own 16-bit counter. That counter clears when its channel captures or matches. Channels 0 and 1 can count edge strobes instead of prescaler steps, so they act as timer/counters. Channels 2 and 3 are plain timers.

Each channel is set either for input capture or for output compare. A capture stores the current count and sets a sticky capture flag. A compare sets a sticky match flag. The configuration inputs are register-style levels that come from the surrounding logic. The edge strobes come from an external edge detector.

A small controller sequences the modes and has three named states. ST_FREE runs the shared counter. ST_SPLIT runs the per-channel counters. ST_SWITCH lasts one cycle and clears every counter and the prescaler. The transitions are:
- ST_FREE to ST_SWITCH when `mode_split` is 1.
- ST_SPLIT to ST_SWITCH when `mode_split` is 0.
- ST_SWITCH to ST_SPLIT when `mode_split` is 1, otherwise to ST_FREE.
- Every other case holds the current state.

Top module: `capcmp_timer`

## Requirements
- R1: After reset the controller is in ST_FREE, and all counters, capture registers and flags are zero.
- R2: A count step occurs once every 32·2^sel clock cycles for `presc_sel` values 0 to 5. Values 6 and 7 give divide-by-1024. After reset or ST_SWITCH, the first step comes at the 32·2^sel-th clock edge.
- R3: In ST_FREE, `base_cnt` advances by one on each step and wraps at 32 bits. It changes on no other cycle, and captures and matches never clear it.
- R4: In ST_FREE, a strobe on a channel set for capture (`cap_sel` bit = 1) copies the value `base_cnt` held before that edge into the channel's capture register, and sets its capture flag.
- R5: In ST_FREE, a channel set for compare (`cap_sel` bit = 0) sets its match flag on a step at which `base_cnt` equals the channel's 32-bit compare value.
- R6: In ST_SPLIT, a compare channel's 16-bit counter advances on each of its steps. When it equals the low 16 bits of the compare value at a step, it becomes 0 and the match flag is set.
- R7: In ST_SPLIT, a capture strobe stores the channel's 16-bit count, zero-extended, into the capture register and sets the capture flag. The counter clears to 0 on that edge, even if a step coincides. Between events, a capture channel's counter advances on prescaler steps.
- R8: For channel 0 or 1 in compare mode with its `cnt_op` bit = 1, the channel steps on its edge strobe instead of the prescaler. Channels 2 and 3 always use the prescaler.
- R9: Flags are sticky. A 1 on a `clr_*_flag` bit clears the flag. A set and a clear in the same cycle leave the flag set.
- R10: A change of `mode_split` causes exactly one ST_SWITCH cycle. That cycle zeroes `base_cnt`, all channel counters and the prescaler, ignores strobes, and leaves capture registers and flags untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_split | input | 1 | 0 selects the shared 32-bit base, 1 selects 16-bit split mode |
| presc_sel | input | 3 | Prescaler select, divide by 32·2^sel, saturating at 1024 |
| cap_sel | input | 4 | Per channel: 1 = input capture, 0 = output compare |
| cnt_op | input | 2 | Channels 0 and 1: 1 = count edge strobes (compare mode) |
| cmp_val | input | 128 | Compare values, channel i in bits [32i+31:32i] |
| edge_evt | input | 4 | One-cycle edge strobes per channel |
| clr_cap_flag | input | 4 | Write-one-to-clear strobes for the capture flags |
| clr_match_flag | input | 4 | Write-one-to-clear strobes for the match flags |
| base_cnt | output | 32 | Shared free-running counter |
| chan_cnt | output | 64 | Split-mode counters, channel i in bits [16i+15:16i] |
| cap_reg | output | 128 | Capture registers, channel i in bits [32i+31:32i] |
| cap_flag | output | 4 | Sticky capture flags |
| match_flag | output | 4 | Sticky match flags |

## Verification
The hardest cases to reach are the ones where a step, a strobe and a flag clear land on the same edge. One example is a split-mode capture arriving on a prescaler step. Another is a set and a clear of the same flag in one cycle. The stimulus keeps the prescaler at its fastest setting most of the time. It uses compare values below 16 so that matches are frequent, and it fires strobes and clears at random on every cycle, so these collisions recur many times. Occasional mode flips pass through ST_SWITCH with flags and captures already populated.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
    typedef enum logic [1:0] {
        ST_FREE   = 2'd0,
        ST_SPLIT  = 2'd1,
        ST_SWITCH = 2'd2
    } tmr_state_e;

    localparam int BASE_SHIFT = 5;
    localparam int SEL_MAX    = 5;
    localparam int PRE_W      = BASE_SHIFT + SEL_MAX + 1;
endpackage

// File: rtl/capcmp_prescaler.sv
module capcmp_prescaler
    import capcmp_pkg::*;
#(
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [SELW-1:0] sel,
    output logic            tick
);
    logic [PRE_W-1:0] pre_q;
    logic [SELW-1:0]  sel_c;
    logic [PRE_W-1:0] lim;

    always_comb begin
        sel_c = (sel > SELW'(SEL_MAX)) ? SELW'(SEL_MAX) : sel;
        lim   = (PRE_W'(1) << (PRE_W'(sel_c) + PRE_W'(BASE_SHIFT))) - PRE_W'(1);
        tick  = !clr && (pre_q >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_q <= '0;
        else if (clr)    pre_q <= '0;
        else if (tick)   pre_q <= '0;
        else             pre_q <= pre_q + PRE_W'(1);
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/capcmp_mode_fsm.sv
module capcmp_mode_fsm
    import capcmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_split,
    output logic free_en,
    output logic split_en,
    output logic clr_all
);
    tmr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE:   if (mode_split)  state_d = ST_SWITCH;
            ST_SPLIT:  if (!mode_split) state_d = ST_SWITCH;
            ST_SWITCH: state_d = mode_split ? ST_SPLIT : ST_FREE;
            default:   state_d = ST_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        free_en  = 1'b0;
        split_en = 1'b0;
        clr_all  = 1'b0;
        unique case (state_q)
            ST_FREE:   free_en  = 1'b1;
            ST_SPLIT:  split_en = 1'b1;
            ST_SWITCH: clr_all  = 1'b1;
            default:   clr_all  = 1'b1;
        endcase
    end

    // R10
    switch_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> !clr_all);
endmodule

// File: rtl/capcmp_channel.sv
module capcmp_channel #(
    parameter int BW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          free_en,
    input  logic          split_en,
    input  logic          clr_all,
    input  logic          tick,
    input  logic          cap_sel,
    input  logic          cnt_op,
    input  logic          edge_evt,
    input  logic [BW-1:0] cmp,
    input  logic [BW-1:0] base,
    input  logic          clr_cap,
    input  logic          clr_match,
    output logic [CW-1:0] cnt,
    output logic [BW-1:0] cap,
    output logic          cap_flag,
    output logic          match_flag
);
    logic step, cap_ev, match_ev;

    always_comb begin
        step     = (cnt_op && !cap_sel) ? edge_evt : tick;
        cap_ev   = cap_sel && edge_evt && (free_en || split_en);
        match_ev = !cap_sel && ((free_en && tick && base == cmp) ||
                                (split_en && step && cnt == cmp[CW-1:0]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr_all) begin
            cnt <= '0;
        end else if (split_en) begin
            if (cap_ev || match_ev) cnt <= '0;
            else if (step)          cnt <= cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap        <= '0;
            cap_flag   <= 1'b0;
            match_flag <= 1'b0;
        end else begin
            if (cap_ev) cap <= free_en ? base : BW'(cnt);
            cap_flag   <= cap_ev   | (cap_flag   & ~clr_cap);
            match_flag <= match_ev | (match_flag & ~clr_match);
        end
    end

    // R7
    cap_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (split_en && cap_ev) |=> (cnt == '0));
    // R6
    match_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (split_en && match_ev) |=> (cnt == '0));
    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ev && clr_cap) |=> cap_flag);
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer #(
    parameter int NCH  = 4,
    parameter int BW   = 32,
    parameter int CW   = 16,
    parameter int NCNT = 2,
    parameter int SELW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_split,
    input  logic [SELW-1:0]   presc_sel,
    input  logic [NCH-1:0]    cap_sel,
    input  logic [NCNT-1:0]   cnt_op,
    input  logic [NCH*BW-1:0] cmp_val,
    input  logic [NCH-1:0]    edge_evt,
    input  logic [NCH-1:0]    clr_cap_flag,
    input  logic [NCH-1:0]    clr_match_flag,
    output logic [BW-1:0]     base_cnt,
    output logic [NCH*CW-1:0] chan_cnt,
    output logic [NCH*BW-1:0] cap_reg,
    output logic [NCH-1:0]    cap_flag,
    output logic [NCH-1:0]    match_flag
);
    logic free_en, split_en, clr_all, tick;

    capcmp_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_split(mode_split),
        .free_en(free_en), .split_en(split_en), .clr_all(clr_all)
    );

    capcmp_prescaler #(.SELW(SELW)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(clr_all), .sel(presc_sel), .tick(tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                base_cnt <= '0;
        else if (clr_all)          base_cnt <= '0;
        else if (free_en && tick)  base_cnt <= base_cnt + BW'(1);
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic op_i;
        if (i < NCNT) begin : g_cnt
            assign op_i = cnt_op[i];
        end else begin : g_tmr
            assign op_i = 1'b0;
        end
        capcmp_channel #(.BW(BW), .CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .free_en(free_en), .split_en(split_en), .clr_all(clr_all),
            .tick(tick), .cap_sel(cap_sel[i]), .cnt_op(op_i),
            .edge_evt(edge_evt[i]), .cmp(cmp_val[i*BW +: BW]), .base(base_cnt),
            .clr_cap(clr_cap_flag[i]), .clr_match(clr_match_flag[i]),
            .cnt(chan_cnt[i*CW +: CW]), .cap(cap_reg[i*BW +: BW]),
            .cap_flag(cap_flag[i]), .match_flag(match_flag[i])
        );
    end

    // R3
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_en && !tick) |=> $stable(base_cnt));
endmodule

// File: tb/capcmp_timer_bench.sv
`timescale 1ns/1ps
module capcmp_timer_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_split = 1'b0;
    logic [2:0] presc_sel = '0;
    logic [3:0] cap_sel = '0;
    logic [1:0] cnt_op = '0;
    logic [127:0] cmp_val = '0;
    logic [3:0] edge_evt = '0, clr_cap_flag = '0, clr_match_flag = '0;
    logic [31:0] base_cnt;
    logic [63:0] chan_cnt;
    logic [127:0] cap_reg;
    logic [3:0] cap_flag, match_flag;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    capcmp_timer u_capcmp_timer (
        .clk(clk), .rst_n(rst_n), .mode_split(mode_split), .presc_sel(presc_sel),
        .cap_sel(cap_sel), .cnt_op(cnt_op), .cmp_val(cmp_val), .edge_evt(edge_evt),
        .clr_cap_flag(clr_cap_flag), .clr_match_flag(clr_match_flag),
        .base_cnt(base_cnt), .chan_cnt(chan_cnt), .cap_reg(cap_reg),
        .cap_flag(cap_flag), .match_flag(match_flag)
    );

    // reference model: 0 free, 1 split, 2 switch
    int m_st, m_pre;
    logic [31:0] m_base;
    logic [15:0] m_cnt [4];
    logic [31:0] m_cap [4];
    logic [3:0] m_cf, m_mf;

    function automatic int div_of(input logic [2:0] s);
        return 32 << ((s > 3'd5) ? 5 : int'(s));
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_pre = 0; m_base = '0; m_cf = '0; m_mf = '0;
            for (int i = 0; i < 4; i++) begin m_cnt[i] = '0; m_cap[i] = '0; end
        end else begin
            bit sw, fr, sp, tk;
            logic [31:0] ob;
            sw = (m_st == 2); fr = (m_st == 0); sp = (m_st == 1);
            tk = !sw && (m_pre >= div_of(presc_sel) - 1);
            ob = m_base;
            m_pre  = (sw || tk) ? 0 : m_pre + 1;
            m_base = sw ? '0 : ((fr && tk) ? m_base + 1 : m_base);
            for (int i = 0; i < 4; i++) begin
                bit st, cp, mt;
                logic [31:0] cv;
                cv = cmp_val[i*32 +: 32];
                st = (i < 2 && cnt_op[i] && !cap_sel[i]) ? edge_evt[i] : tk;
                cp = cap_sel[i] && edge_evt[i] && (fr || sp);
                mt = !cap_sel[i] && ((fr && tk && ob == cv) ||
                                     (sp && st && m_cnt[i] == cv[15:0]));
                if (cp) m_cap[i] = fr ? ob : {16'h0, m_cnt[i]};
                if (sw) m_cnt[i] = '0;
                else if (sp) begin
                    if (cp || mt) m_cnt[i] = '0;
                    else if (st)  m_cnt[i] = m_cnt[i] + 1'b1;
                end
                m_cf[i] = cp | (m_cf[i] & ~clr_cap_flag[i]);
                m_mf[i] = mt | (m_mf[i] & ~clr_match_flag[i]);
            end
            if (sw) m_st = mode_split ? 1 : 0;
            else if (fr && mode_split) m_st = 2;
            else if (sp && !mode_split) m_st = 2;
        end
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R3 base_cnt", 128'(base_cnt), 128'(m_base));
        for (int i = 0; i < 4; i++) begin
            chk("R6 R7 R8 R10 chan_cnt", 128'(chan_cnt[i*16 +: 16]), 128'(m_cnt[i]));
            chk("R4 R7 cap_reg", 128'(cap_reg[i*32 +: 32]), 128'(m_cap[i]));
        end
        chk("R4 R9 cap_flag", 128'(cap_flag), 128'(m_cf));
        chk("R5 R6 R9 match_flag", 128'(match_flag), 128'(m_mf));
    endtask

    task automatic step_cycle();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        process::self().srandom(32'd1234);
        repeat (2) @(negedge clk);
        chk("R1 reset base", 128'(base_cnt), 128'h0);
        chk("R1 reset flags", 128'({cap_flag, match_flag}), 128'h0);
        chk("R1 reset caps", cap_reg, 128'h0);
        rst_n = 1'b1;
        // R2: divide-by-32 from reset
        repeat (31) @(negedge clk);
        chk("R2 no step before 32", 128'(base_cnt), 128'h0);
        @(negedge clk);
        chk("R2 step at 32", 128'(base_cnt), 128'h1);
        // R8: counter operation on channel 0
        mode_split = 1'b1; cnt_op = 2'b01; cap_sel = 4'b0000;
        cmp_val[31:0] = 32'd100;
        step_cycle(); step_cycle();
        for (int k = 0; k < 3; k++) begin
            edge_evt = 4'b0001; step_cycle();
            edge_evt = 4'b0000; step_cycle();
        end
        chk("R8 ch0 counts strobes", 128'(chan_cnt[15:0]), 128'd3);
        // R10: back to free mode clears counters
        mode_split = 1'b0;
        step_cycle(); step_cycle();
        chk("R10 counters cleared", 128'(chan_cnt), 128'h0);
        chk("R10 base cleared", 128'(base_cnt), 128'h0);
        // random phase
        for (int n = 0; n < 30000; n++) begin
            edge_evt       = 4'($urandom) & 4'($urandom) & 4'($urandom);
            clr_cap_flag   = 4'($urandom) & 4'($urandom);
            clr_match_flag = 4'($urandom) & 4'($urandom);
            if ($urandom_range(0, 2499) == 0) mode_split = ~mode_split;
            if ($urandom_range(0, 999) == 0)
                presc_sel = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'd0;
            if ($urandom_range(0, 299) == 0) begin
                cap_sel = 4'($urandom);
                cnt_op  = 2'($urandom);
            end
            if ($urandom_range(0, 199) == 0)
                for (int i = 0; i < 4; i++) cmp_val[i*32 +: 32] = 32'($urandom_range(0, 15));
            step_cycle();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc > 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule